// File: doc/BRIEF.md
# Four-Channel Compare-Match Timer with PWM Output

This block is a timer unit with four independent 16-bit channels, reached over a simple 16-bit register bus with address, write enable, write data and combinational read data. Each channel holds an up-counter fed by a prescaled tick with a selectable counting edge. It has four compare registers (A to D), one of which may be chosen to reset the counter. It also drives one output pin from compare-match actions, sets four sticky match flags and raises one interrupt line masked by an enable register.

A single shared start register holds one run bit per channel. In normal mode the pin takes the A-match action each time the counter matches A. In PWM mode the chosen clearing register sets the period and register A sets the duty point: the pin sits at its initial level, takes the A action after the A match, and goes back to the initial level when the clearing match resets the counter. While a channel is stopped, writing its pin-control register drives the pin straight to the initial level, so software can park the pin high or low without a glitch.

Byte addresses: the start register is at 0x00. Channel n occupies a window starting at 0x10 + 0x40*n. Inside each window the registers sit at a stride of 4: control 0x00, mode 0x04, pin control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14, compare A 0x18, B 0x1C, C 0x20, D 0x24.

Top module: `tpu_pwm_unit`

## Requirements
- R1: Every mapped register reads back its stored value, zero-extended. Control keeps bits [7:0], mode keeps bits {6,5,4,1,0} (0xFFFF reads 0x0073), pin control keeps [2:0], enable and status keep [3:0], and counter and compares keep all 16 bits. Any other address (gaps, offsets not a multiple of 4, 0x28 and above inside a window) reads zero and ignores writes.
- R2: After reset every register, pin and interrupt is zero. A write to 0x00 loads the run bits, with bit n running channel n. A stopped channel's counter does not change, whatever the other channels do.
- R3: While running, the counter advances by one on every count tick. A bus write to the counter takes effect only while the channel is stopped and is ignored while it runs.
- R4: Control bits [1:0] select divide-by 1, 4, 16 or 64 (codes 0 to 3). A 6-bit prescaler p is held at 0 while stopped and increments each running cycle. For divide D>1, the counter ticks on cycles where (p mod D) = D/2-1 when control bits [4:3] = 0 (rising), where (p mod D) = D-1 when they are 1 (falling), and on both when they are 2 or 3. Divide-by-1 ticks every running cycle for any edge code.
- R5: Control bits [7:5] pick the clear source: 1 = A, 2 = B, 5 = C, 6 = D. Any other code never clears. On a tick where the counter equals the selected compare value, the counter becomes 0 rather than advancing. Without a clear, it wraps from 0xFFFF to 0.
- R6: Status bit k (k = 0..3 for A..D) sets on a tick where the counter equals compare k. A status write ANDs the data into the flags: writing 0 clears a bit and writing 1 leaves it unchanged.
- R7: A channel's interrupt is high exactly when some status bit is set whose bit in the enable register is also set.
- R8: Pin control bit 2 is the initial level and bits [1:0] the A-match action (0 hold, 1 low, 2 high, 3 toggle). With mode bits [1:0] not equal to 2 (normal mode), the pin takes the action on each tick where the counter equals A and never returns on its own. Mode bits 6..4 have no effect.
- R9: With mode bits [1:0] = 2 (PWM), a tick where the clear source matches sets the pin to the initial level; otherwise a tick matching A applies the A action. With clear on B and A < B, the pin is at the action level exactly while the counter is in A+1..B. With A >= B it stays at the initial level.
- R10: Writing pin control while the channel is stopped drives the pin to data bit 2 on the next cycle. While running, such a write updates the stored code but leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One output pin per channel |
| irq | output | 4 | One interrupt per channel |

## Verification
The properties assume that a write strobe only lasts as long as the bus holds a stable address and data in that cycle. They also assume the counter moves only by one step, a clear to zero, or not at all, which holds only because bus writes to a running counter are dropped. The stimulus writes counters, pin codes and the start register only at cycle boundaries set by the bench. It parks and reconfigures channels only after stopping them, so every waveform begins from a known prescaler phase and counter value.

// File: rtl/tpu_pkg.sv
package tpu_pkg;

    localparam int TW       = 16;
    localparam int PRE_W    = 6;
    localparam int NUM_CMP  = 4;
    localparam int NUM_REGS = 10;

    typedef enum logic [3:0] {
        RG_CTRL = 4'd0,
        RG_MODE = 4'd1,
        RG_IOC  = 4'd2,
        RG_IER  = 4'd3,
        RG_STS  = 4'd4,
        RG_CNT  = 4'd5,
        RG_CMPA = 4'd6,
        RG_CMPB = 4'd7,
        RG_CMPC = 4'd8,
        RG_CMPD = 4'd9
    } reg_idx_e;

    typedef struct packed {
        logic [7:0]                   ctrl;
        logic [6:0]                   mode;
        logic [2:0]                   ioc;
        logic [NUM_CMP-1:0]           ier;
        logic [NUM_CMP-1:0]           sts;
        logic [TW-1:0]                cnt;
        logic [NUM_CMP-1:0][TW-1:0]   cmp;
        logic                         pin;
    } chan_state_t;

    localparam logic [6:0] MODE_MASK = 7'h73;
    localparam logic [1:0] MODE_PWM  = 2'd2;

    function automatic logic pin_action(input logic [1:0] act, input logic cur);
        logic nxt;
        case (act)
            2'd1:    nxt = 1'b0;
            2'd2:    nxt = 1'b1;
            2'd3:    nxt = ~cur;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic clear_pick(input logic [2:0] src,
                                        input logic [NUM_CMP-1:0] hit);
        logic sel;
        case (src)
            3'd1:    sel = hit[0];
            3'd2:    sel = hit[1];
            3'd5:    sel = hit[2];
            3'd6:    sel = hit[3];
            default: sel = 1'b0;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/tpu_prescaler.sv
module tpu_prescaler
    import tpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_sel,
    input  logic [1:0] edge_sel,
    output logic       tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;
    logic [PRE_W-1:0] half;
    logic [PRE_W-1:0] low;
    logic             at_rise;
    logic             at_fall;
    logic             edge_ev;

    always_comb begin
        st_d     = st_q;
        st_d.pre = run ? st_q.pre + 1'b1 : '0;

        span    = (PRE_W+1)'(1) << {div_sel, 1'b0};
        mask    = span[PRE_W-1:0] - 1'b1;
        half    = span[PRE_W:1] - 1'b1;
        low     = st_q.pre & mask;
        at_rise = (low == half);
        at_fall = (low == mask);

        case (edge_sel)
            2'd0:    edge_ev = at_rise;
            2'd1:    edge_ev = at_fall;
            default: edge_ev = at_rise | at_fall;
        endcase

        tick = run && ((div_sel == 2'd0) || edge_ev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tpu_channel.sv
module tpu_channel
    import tpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_en,
    input  reg_idx_e      wr_idx,
    input  logic [TW-1:0] wdata,
    output chan_state_t   regs_o,
    output logic          pin_o,
    output logic          irq_o
);

    chan_state_t        st_d, st_q;
    logic               tick;
    logic [NUM_CMP-1:0] hit;
    logic               clr_hit;
    logic               pwm_mode;

    tpu_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_sel  (st_q.ctrl[1:0]),
        .edge_sel (st_q.ctrl[4:3]),
        .tick     (tick)
    );

    always_comb begin
        st_d = st_q;

        for (int k = 0; k < NUM_CMP; k++) begin
            hit[k] = tick && (st_q.cnt == st_q.cmp[k]);
        end
        clr_hit  = clear_pick(st_q.ctrl[7:5], hit);
        pwm_mode = (st_q.mode[1:0] == MODE_PWM);

        if (wr_en) begin
            case (wr_idx)
                RG_CTRL: st_d.ctrl = wdata[7:0];
                RG_MODE: st_d.mode = wdata[6:0] & MODE_MASK;
                RG_IOC: begin
                    st_d.ioc = wdata[2:0];
                    if (!run) begin
                        st_d.pin = wdata[2];
                    end
                end
                RG_IER:  st_d.ier = wdata[NUM_CMP-1:0];
                RG_STS:  st_d.sts = st_q.sts & wdata[NUM_CMP-1:0];
                RG_CNT: begin
                    if (!run) begin
                        st_d.cnt = wdata;
                    end
                end
                RG_CMPA: st_d.cmp[0] = wdata;
                RG_CMPB: st_d.cmp[1] = wdata;
                RG_CMPC: st_d.cmp[2] = wdata;
                RG_CMPD: st_d.cmp[3] = wdata;
                default: ;
            endcase
        end

        if (tick) begin
            st_d.cnt = clr_hit ? '0 : st_q.cnt + 1'b1;
            if (pwm_mode && clr_hit) begin
                st_d.pin = st_q.ioc[2];
            end else if (hit[0]) begin
                st_d.pin = pin_action(st_q.ioc[1:0], st_q.pin);
            end
        end

        st_d.sts = st_d.sts | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q;
    assign pin_o  = st_q.pin;
    assign irq_o  = |(st_q.sts & st_q.ier);

endmodule

// File: rtl/tpu_addr_dec.sv
module tpu_addr_dec
    import tpu_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 9,
    parameter int CH_BASE   = 16,
    parameter int CH_STRIDE = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              start_hit,
    output logic [NUM_CH-1:0] ch_sel,
    output reg_idx_e          ch_idx [NUM_CH]
);

    localparam int WIN_SPAN = 4 * NUM_REGS;

    assign start_hit = (addr == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + c * CH_STRIDE);
        logic [ADDR_W-1:0] rel;

        always_comb begin
            rel       = addr - BASE;
            ch_sel[c] = (addr >= BASE) && (rel < ADDR_W'(WIN_SPAN)) && (rel[1:0] == 2'b00);
            ch_idx[c] = reg_idx_e'(rel[5:2]);
        end
    end

endmodule

// File: rtl/tpu_pwm_unit.sv
module tpu_pwm_unit
    import tpu_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 9,
    parameter int CH_BASE   = 16,
    parameter int CH_STRIDE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [TW-1:0]     bus_wdata,
    output logic [TW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0]              start_d, start_q;
    logic                           start_hit;
    logic [NUM_CH-1:0]              ch_sel;
    reg_idx_e                       ch_idx [NUM_CH];
    chan_state_t                    ch_regs [NUM_CH];
    logic [NUM_CH-1:0][TW-1:0]      ch_cnt;
    logic [NUM_CH-1:0][NUM_CMP-1:0] ch_sts;

    tpu_addr_dec #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .CH_BASE   (CH_BASE),
        .CH_STRIDE (CH_STRIDE)
    ) u_dec (
        .addr      (bus_addr),
        .start_hit (start_hit),
        .ch_sel    (ch_sel),
        .ch_idx    (ch_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tpu_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (start_q[c]),
            .wr_en  (bus_we && ch_sel[c]),
            .wr_idx (ch_idx[c]),
            .wdata  (bus_wdata),
            .regs_o (ch_regs[c]),
            .pin_o  (pwm_out[c]),
            .irq_o  (irq[c])
        );
        assign ch_cnt[c] = ch_regs[c].cnt;
        assign ch_sts[c] = ch_regs[c].sts;
    end

    always_comb begin
        start_d = start_q;
        if (bus_we && start_hit) begin
            start_d = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
        end else begin
            start_q <= start_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (start_hit) begin
            bus_rdata = TW'(start_q);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel[c]) begin
                case (ch_idx[c])
                    RG_CTRL: bus_rdata = TW'(ch_regs[c].ctrl);
                    RG_MODE: bus_rdata = TW'(ch_regs[c].mode);
                    RG_IOC:  bus_rdata = TW'(ch_regs[c].ioc);
                    RG_IER:  bus_rdata = TW'(ch_regs[c].ier);
                    RG_STS:  bus_rdata = TW'(ch_sts[c]);
                    RG_CNT:  bus_rdata = ch_cnt[c];
                    RG_CMPA: bus_rdata = ch_regs[c].cmp[0];
                    RG_CMPB: bus_rdata = ch_regs[c].cmp[1];
                    RG_CMPC: bus_rdata = ch_regs[c].cmp[2];
                    RG_CMPD: bus_rdata = ch_regs[c].cmp[3];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tpu_pwm_unit_chk.sv
module tpu_pwm_unit_chk
    import tpu_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 9,
    parameter int CH_BASE   = 16,
    parameter int CH_STRIDE = 64
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_we,
    input logic                           lvl_bit,
    input logic [NUM_CH-1:0]              start_bits,
    input logic [NUM_CH-1:0]              run,
    input logic [NUM_CH-1:0][TW-1:0]      cnt,
    input logic [NUM_CH-1:0][NUM_CMP-1:0] sts,
    input logic [NUM_CH-1:0]              pwm_out,
    input logic [NUM_CH-1:0]              irq
);

    // R2: the start register takes the written run bits
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == '0) |=> (run == $past(start_bits)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_IOC = ADDR_W'(CH_BASE + i * CH_STRIDE + 4 * int'(RG_IOC));
        localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(CH_BASE + i * CH_STRIDE + 4 * int'(RG_STS));
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CH_BASE + i * CH_STRIDE + 4 * int'(RG_CNT));

        // R2: a stopped counter only changes by a bus write
        a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !(bus_we && bus_addr == A_CNT)) |=> $stable(cnt[i]));

        // R3: a running counter steps by one, clears, or waits for a tick
        a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
            run[i] |=> ((cnt[i] == TW'($past(cnt[i]) + 1'b1)) || (cnt[i] == '0) || $stable(cnt[i])));

        // R6: flags stay set unless the status register is written
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_we && bus_addr == A_STS) |=> ((sts[i] & $past(sts[i])) == $past(sts[i])));

        // R7: no interrupt without a flag
        a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (sts[i] != '0));

        // R10: parking a stopped pin
        a_r10_park: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && bus_we && bus_addr == A_IOC) |=> (pwm_out[i] == $past(lvl_bit)));
    end

endmodule

bind tpu_pwm_unit tpu_pwm_unit_chk #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .CH_BASE   (CH_BASE),
    .CH_STRIDE (CH_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .lvl_bit    (bus_wdata[2]),
    .start_bits (bus_wdata[NUM_CH-1:0]),
    .run        (start_q),
    .cnt        (ch_cnt),
    .sts        (ch_sts),
    .pwm_out    (pwm_out),
    .irq        (irq)
);

// File: tb/tpu_pwm_unit_tb.sv
`timescale 1ns/1ps
module tpu_pwm_unit_tb;

    localparam int CTL = 0, MOD = 1, IOC = 2, IEN = 3, STS = 4, CNT = 5;
    localparam int CA = 6, CB = 7, CC = 8, CD = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tpu_pwm_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    function automatic logic [8:0] ra(input int ch, input int r);
        return 9'(16 + ch * 64 + r * 4);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset;
        logic [15:0] v;
        rd(9'h000, v);       chk("R2 start after reset", v, 16'h0);
        rd(ra(0, CTL), v);   chk("R2 ctrl after reset", v, 16'h0);
        rd(ra(2, CNT), v);   chk("R2 counter after reset", v, 16'h0);
        chk("R2 pins after reset", 16'(pwm_out), 16'h0);
        chk("R2 irq after reset", 16'(irq), 16'h0);
    endtask

    task automatic test_regs;
        logic [15:0] v;
        wr(ra(1, CTL), 16'hFFFF); rd(ra(1, CTL), v); chk("R1 ctrl mask", v, 16'h00FF);
        wr(ra(1, MOD), 16'hFFFF); rd(ra(1, MOD), v); chk("R1 mode mask", v, 16'h0073);
        wr(ra(1, IOC), 16'hFFFF); rd(ra(1, IOC), v); chk("R1 ioc mask", v, 16'h0007);
        chk("R10 park high", 16'(pwm_out[1]), 16'h1);
        wr(ra(1, IEN), 16'hFFFF); rd(ra(1, IEN), v); chk("R1 enable mask", v, 16'h000F);
        wr(ra(1, CC), 16'hBEEF);  rd(ra(1, CC), v);  chk("R1 compare C", v, 16'hBEEF);
        wr(ra(1, 10), 16'h1234);  rd(ra(1, 10), v);  chk("R1 past window", v, 16'h0);
        rd(9'h006, v);                               chk("R1 gap", v, 16'h0);
        rd(ra(1, CA) + 9'd1, v);                     chk("R1 odd offset", v, 16'h0);
        wr(9'h004, 16'hFFFF);     rd(9'h000, v);     chk("R1 unmapped write ignored", v, 16'h0);
        wr(ra(1, IOC), 16'h0);
        wr(ra(1, CTL), 16'h0);
        wr(ra(1, MOD), 16'h0);
        wr(ra(1, IEN), 16'h0);
    endtask

    task automatic test_count;
        logic [15:0] v;
        wr(ra(0, CNT), 16'h0010);
        wr(9'h000, 16'h0001);
        wait_cyc(9);
        wr(9'h000, 16'h0000);
        rd(ra(0, CNT), v); chk("R3 div1 count", v, 16'h001A);
        wr(ra(0, CNT), 16'h0100);
        wr(9'h000, 16'h0001);
        wr(ra(0, CNT), 16'h0000);
        wr(9'h000, 16'h0000);
        rd(ra(0, CNT), v); chk("R3 write while running ignored", v, 16'h0102);
        rd(ra(1, CNT), v); chk("R2 stopped channel unchanged", v, 16'h0000);
    endtask

    task automatic presc_case(input logic [15:0] ctl, input int k, input logic [15:0] exp);
        logic [15:0] v;
        wr(ra(1, CNT), 16'h0);
        wr(ra(1, CTL), ctl);
        wr(9'h000, 16'h0002);
        wait_cyc(k);
        wr(9'h000, 16'h0000);
        rd(ra(1, CNT), v);
        chk($sformatf("R4 prescale ctrl=0x%02h", ctl), v, exp);
    endtask

    task automatic test_presc;
        presc_case(16'h00, 14, 16'd15);
        presc_case(16'h01, 14, 16'd4);
        presc_case(16'h09, 14, 16'd3);
        presc_case(16'h11, 14, 16'd7);
        presc_case(16'h19, 14, 16'd7);
        presc_case(16'h02, 14, 16'd1);
        presc_case(16'h03, 40, 16'd1);
        wr(ra(1, CTL), 16'h0);
    endtask

    task automatic run_ch0(input logic [15:0] ctl, input logic [15:0] c0, input int k);
        wr(ra(0, CTL), ctl);
        wr(ra(0, CNT), c0);
        wr(9'h000, 16'h0001);
        wait_cyc(k);
        wr(9'h000, 16'h0000);
    endtask

    task automatic test_clear;
        logic [15:0] v;
        wr(ra(0, CA), 16'h8000);
        wr(ra(0, CB), 16'h0004);
        wr(ra(0, CC), 16'h8000);
        wr(ra(0, CD), 16'h8000);
        wr(ra(0, STS), 16'h0);
        run_ch0(16'h40, 16'h0, 11);
        rd(ra(0, CNT), v); chk("R5 clear on B", v, 16'd2);
        rd(ra(0, STS), v); chk("R6 flag B", v, 16'h0002);
        chk("R7 masked irq", 16'(irq[0]), 16'h0);
        wr(ra(0, IEN), 16'h0001);
        chk("R7 other bit enabled", 16'(irq[0]), 16'h0);
        wr(ra(0, IEN), 16'h0002);
        chk("R7 irq raised", 16'(irq[0]), 16'h1);
        wr(ra(0, STS), 16'hFFFF);
        rd(ra(0, STS), v); chk("R6 write one keeps", v, 16'h0002);
        wr(ra(0, STS), 16'h0000);
        rd(ra(0, STS), v); chk("R6 write zero clears", v, 16'h0);
        chk("R7 irq dropped", 16'(irq[0]), 16'h0);
        wr(ra(0, IEN), 16'h0);
        wr(ra(0, CC), 16'h0002);
        run_ch0(16'hA0, 16'h0, 12);
        rd(ra(0, CNT), v); chk("R5 clear on C", v, 16'd1);
        rd(ra(0, STS), v); chk("R6 flag C", v, 16'h0004);
        wr(ra(0, CD), 16'h0006);
        run_ch0(16'hC0, 16'h0, 9);
        rd(ra(0, CNT), v); chk("R5 clear on D", v, 16'd3);
        rd(ra(0, STS), v); chk("R6 flags B C D", v, 16'h000E);
        run_ch0(16'h00, 16'hFFFE, 2);
        rd(ra(0, CNT), v); chk("R5 wrap no clear", v, 16'h0001);
        run_ch0(16'hE0, 16'hFFFE, 2);
        rd(ra(0, CNT), v); chk("R5 reserved code no clear", v, 16'h0001);
        wr(ra(0, CA), 16'h0003);
        run_ch0(16'h20, 16'h0, 8);
        rd(ra(0, CNT), v); chk("R5 clear on A", v, 16'd1);
    endtask

    task automatic wave(input int ch, input logic [2:0] ioc, input logic [15:0] mode,
                        input logic [15:0] a, input logic [15:0] b, input int cyc, input string req);
        logic [15:0] mc;
        logic        mp;
        logic        pwm;
        pwm = (mode[1:0] == 2'd2);
        wr(9'h000, 16'h0);
        wr(ra(ch, CNT), 16'h0);
        wr(ra(ch, CA), a);
        wr(ra(ch, CB), b);
        wr(ra(ch, CTL), 16'h0040);
        wr(ra(ch, MOD), mode);
        wr(ra(ch, IOC), 16'(ioc));
        mc = 16'h0;
        mp = ioc[2];
        chk({req, " initial level"}, 16'(pwm_out[ch]), 16'(mp));
        wr(9'h000, 16'(1 << ch));
        chk({req, " after start"}, 16'(pwm_out[ch]), 16'(mp));
        for (int n = 0; n < cyc; n++) begin
            @(posedge clk);
            if (pwm && mc == b) begin
                mp = ioc[2];
            end else if (mc == a) begin
                case (ioc[1:0])
                    2'd1: mp = 1'b0;
                    2'd2: mp = 1'b1;
                    2'd3: mp = ~mp;
                    default: ;
                endcase
            end
            mc = (mc == b) ? 16'h0 : mc + 16'h1;
            @(negedge clk);
            chk($sformatf("%s cycle %0d", req, n), 16'(pwm_out[ch]), 16'(mp));
        end
        wr(9'h000, 16'h0);
    endtask

    task automatic test_wave;
        wave(2, 3'b010, 16'h0002, 16'd2, 16'd5, 20, "R9 pwm set");
        wave(2, 3'b101, 16'h0072, 16'd1, 16'd3, 12, "R9 pwm inverse");
        wave(2, 3'b010, 16'h0002, 16'd5, 16'd5, 12, "R9 pwm duty at period");
        wave(3, 3'b011, 16'h0070, 16'd2, 16'd4, 16, "R8 normal toggle");
        wave(3, 3'b010, 16'h0000, 16'd1, 16'd3, 10, "R8 normal high");
        wave(3, 3'b100, 16'h0000, 16'd1, 16'd3, 10, "R8 normal hold");
    endtask

    task automatic test_park;
        logic [15:0] v;
        wr(9'h000, 16'h0);
        wr(ra(3, IOC), 16'h0004); chk("R10 park high", 16'(pwm_out[3]), 16'h1);
        wr(ra(3, IOC), 16'h0000); chk("R10 park low", 16'(pwm_out[3]), 16'h0);
        wr(ra(3, IOC), 16'h0006); chk("R10 park high again", 16'(pwm_out[3]), 16'h1);
        wr(ra(3, IOC), 16'h0000);
        wr(ra(3, CNT), 16'h0);
        wr(ra(3, CA), 16'h8000);
        wr(ra(3, CTL), 16'h0);
        wr(ra(3, MOD), 16'h0);
        wr(9'h000, 16'h0008);
        wr(ra(3, IOC), 16'h0004);
        chk("R10 running write keeps pin", 16'(pwm_out[3]), 16'h0);
        rd(ra(3, IOC), v); chk("R10 running write stores code", v, 16'h0004);
        wr(9'h000, 16'h0);
        chk("R10 pin after stop", 16'(pwm_out[3]), 16'h0);
        wr(ra(3, IOC), 16'h0004);
        chk("R10 park after stop", 16'(pwm_out[3]), 16'h1);
        rd(ra(0, CNT), v); chk("R2 channel 0 untouched", v, 16'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset;
        test_regs;
        test_count;
        test_presc;
        test_clear;
        test_wave;
        test_park;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule